// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block sits on the host side of a parallel flash. It waits for a program or erase that is already running to finish. A one-cycle start pulse makes it issue read cycles through a simple request/acknowledge read port. From every returned word it takes two bits: the status bit that flips on each read while the device is busy (the toggle bit), and the bit that the device raises when an internal time limit is exceeded (the timeout bit). Reads are taken in pairs. If both reads of a pair return the same toggle value, the operation has completed.

A pair may show a toggle while the timeout bit is high. In that case the controller does not give up at once, because the toggle can stop in the same cycle the timeout bit rises. It takes one more pair of reads first. If that pair still toggles, the controller writes the reset command through a request/acknowledge write port and then reports failure. A read budget also forces failure, which guards against a stuck interface.

The host can abandon a poll so that it can do other work. A later start always begins again with a fresh read pair. The result is a one-cycle done pulse and a pass flag. The pass flag stays valid until the next accepted start.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, rd_req_o and wr_req_o are all low.
- R2: A start pulse accepted while idle begins a read pair. The toggle bit sits at data bit TOG_BIT (default 6). If both reads of the pair return the same toggle value, the poll ends with pass_o high after exactly two reads and no write.
- R3: If the two reads of a pair differ in the toggle bit and the timeout bit (data bit TMO_BIT, default 5) of the second read is low, a new read pair follows.
- R4: If the two reads of a pair differ and the timeout bit of the second read is high, exactly one verification pair is read. If that pair shows no toggle, the poll passes with no write.
- R5: If the verification pair still toggles, one write of RST_CMD (default 0xF0) to poll_addr_i is made, and the poll then ends with pass_o low.
- R6: When both reads of a pair match, a high timeout bit has no effect: the result is pass.
- R7: With MAX_READS nonzero, a poll that has taken MAX_READS reads and still needs another read goes to the reset-command write and fails. It never makes more than MAX_READS reads.
- R8: abandon_i during a read phase returns the block to idle with no done pulse and no write. The next start begins from a fresh first read pair.
- R9: busy_o is high from the cycle after an accepted start until the done pulse. done_o lasts one cycle, and busy_o is low in that cycle.
- R10: pass_o holds its value from the done pulse until the next accepted start. A start while busy is ignored.
- R11: rd_req_o and wr_req_o are never high together. Each request holds until it is acknowledged, or until abandon_i withdraws the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (pulse) |
| abandon_i | input | 1 | Give up the current poll without a result |
| poll_addr_i | input | ADDR_W | Address for status reads and the reset-command write |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Write request (reset command) |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last completed poll |

## Verification
The bench builds the block with an 8-bit data path, a 12-bit address and MAX_READS set to 8, keeping the default bit positions and command value. The small read budget lets a device model that never stops toggling hit the forced failure after four pairs. The same budget still leaves room for the multi-pair, verification-pair and abandon-and-resume scenarios to finish on their own.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAIR_A,
    ST_PAIR_B,
    ST_VERIFY_A,
    ST_VERIFY_B,
    ST_CMD_WR
  } poll_state_t;

  // True once the reads taken so far use up a nonzero budget
  function automatic logic budget_spent(input int unsigned reads_taken,
                                        input int unsigned budget);
    return (budget != 0) && (reads_taken >= budget);
  endfunction

  // Two samples of the toggle bit disagree
  function automatic logic bits_differ(input logic a, input logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/tp_read_budget.sv
module tp_read_budget #(
  parameter int unsigned MAX_READS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic fire_i,
  output logic spent_o
);
  import toggle_poll_pkg::*;

  localparam int CNT_W = $clog2(MAX_READS + 2);

  logic [CNT_W-1:0] taken_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) taken_q <= '0;
    else if (fire_i)       taken_q <= taken_q + 1'b1;
  end

  // Spent when the read completing now reaches the budget
  assign spent_o = fire_i && budget_spent(int'(taken_q) + 1, MAX_READS);

endmodule

// File: rtl/tp_flag_capture.sv
module tp_flag_capture #(
  parameter int DATA_W  = 8,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              toggled_o,
  output logic              timeout_o
);
  import toggle_poll_pkg::*;

  logic held_tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_tog_q <= 1'b0;
    else if (hold_i) held_tog_q <= data_i[TOG_BIT];
  end

  assign toggled_o = bits_differ(held_tog_q, data_i[TOG_BIT]);
  assign timeout_o = data_i[TMO_BIT];

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 20,
  parameter int          TOG_BIT   = 6,
  parameter int          TMO_BIT   = 5,
  parameter int unsigned MAX_READS = 4096,
  parameter logic [DATA_W-1:0] RST_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abandon_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o
);
  import toggle_poll_pkg::*;

  poll_state_t state_q, state_d;
  logic done_q, pass_q;

  // Named events, also watched by the checker
  logic start_ok, rd_fire, first_fire, second_fire;
  logic toggled, timeout, spent;
  logic pair_match, recheck, persist_fail, cmd_done;

  assign start_ok    = start_i && (state_q == ST_IDLE);
  assign rd_req_o    = (state_q == ST_PAIR_A) || (state_q == ST_PAIR_B) ||
                       (state_q == ST_VERIFY_A) || (state_q == ST_VERIFY_B);
  assign rd_fire     = rd_req_o && rd_ack_i && !abandon_i;
  assign first_fire  = rd_fire && ((state_q == ST_PAIR_A) || (state_q == ST_VERIFY_A));
  assign second_fire = rd_fire && ((state_q == ST_PAIR_B) || (state_q == ST_VERIFY_B));

  tp_flag_capture #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (first_fire),
    .data_i    (rd_data_i),
    .toggled_o (toggled),
    .timeout_o (timeout)
  );

  tp_read_budget #(.MAX_READS(MAX_READS)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_ok),
    .fire_i  (rd_fire),
    .spent_o (spent)
  );

  assign pair_match   = second_fire && !toggled;
  assign recheck      = second_fire && toggled && timeout && (state_q == ST_PAIR_B);
  assign persist_fail = second_fire && toggled && (state_q == ST_VERIFY_B);
  assign cmd_done     = (state_q == ST_CMD_WR) && wr_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_PAIR_A;
      ST_PAIR_A:
        if (abandon_i)    state_d = ST_IDLE;
        else if (rd_fire) state_d = spent ? ST_CMD_WR : ST_PAIR_B;
      ST_PAIR_B:
        if (abandon_i)       state_d = ST_IDLE;
        else if (pair_match) state_d = ST_IDLE;
        else if (rd_fire)    state_d = spent   ? ST_CMD_WR :
                                       recheck ? ST_VERIFY_A : ST_PAIR_A;
      ST_VERIFY_A:
        if (abandon_i)    state_d = ST_IDLE;
        else if (rd_fire) state_d = spent ? ST_CMD_WR : ST_VERIFY_B;
      ST_VERIFY_B:
        if (abandon_i)         state_d = ST_IDLE;
        else if (pair_match)   state_d = ST_IDLE;
        else if (persist_fail) state_d = ST_CMD_WR;
      ST_CMD_WR:   if (wr_ack_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= pair_match || cmd_done;
      if (start_ok)        pass_q <= 1'b0;
      else if (pair_match) pass_q <= 1'b1;
    end
  end

  assign rd_addr_o = poll_addr_i;
  assign wr_req_o  = (state_q == ST_CMD_WR);
  assign wr_addr_o = poll_addr_i;
  assign wr_data_o = wr_req_o ? RST_CMD : '0;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;

endmodule

// File: rtl/tp_poll_chk.sv
module tp_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rd_req_o,
  input logic wr_req_o,
  input logic wr_ack_i,
  input logic busy_o,
  input logic done_o,
  input logic pass_o,
  input logic pair_match,
  input logic persist_fail
);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> wr_req_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R2
  match_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_match |=> (done_o && pass_o));

  // R5
  persist_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    persist_fail |=> (wr_req_o && !pass_o));

  // R10
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(start_i && !busy_o)) |-> $stable(pass_o));

endmodule

bind toggle_poll_ctrl tp_poll_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .rd_req_o     (rd_req_o),
  .wr_req_o     (wr_req_o),
  .wr_ack_i     (wr_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .pair_match   (pair_match),
  .persist_fail (persist_fail)
);

// File: tb/toggle_poll_ctrl_test.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_test;

  localparam int DW = 8;
  localparam int AW = 12;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abandon_i = 1'b0;
  logic [AW-1:0] poll_addr_i = 12'h5A3;
  logic rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [DW-1:0] rd_data_i = '0, wr_data_o;
  logic wr_req_o, wr_ack_i = 1'b0;
  logic busy_o, done_o, pass_o;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] script [16];
  int rd_cnt = 0, wr_cnt = 0;
  logic [DW-1:0] wr_seen;
  logic [AW-1:0] wr_addr_seen;
  int done_cnt = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(.DATA_W(DW), .ADDR_W(AW), .MAX_READS(LIMIT), .RST_CMD(8'hF0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abandon_i(abandon_i),
    .poll_addr_i(poll_addr_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o));

  // Flash model: acknowledges each request at the next edge
  always @(negedge clk) begin
    if (rd_ack_i) rd_cnt = rd_cnt + 1;
    if (wr_ack_i) wr_cnt = wr_cnt + 1;
    rd_ack_i  = rd_req_o;
    rd_data_i = script[rd_cnt % 16];
    wr_ack_i  = wr_req_o;
    if (wr_req_o) begin
      wr_seen = wr_data_o;
      wr_addr_seen = wr_addr_o;
    end
    if (done_o) done_cnt = done_cnt + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [DW-1:0] c, input logic [DW-1:0] d);
    for (int i = 0; i < 16; i += 4) begin
      script[i] = a; script[i+1] = b; script[i+2] = c; script[i+3] = d;
    end
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
  endtask

  // Waits for done, checks busy until then; returns pass flag
  task automatic run(input string req, output logic res);
    logic busy_ok = 1'b1;
    int guard = 0;
    pulse_start();
    while (!done_o && guard < 200) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk); #2;
      guard++;
    end
    check(guard < 200, {req, " completes"}, guard, 0);
    check(busy_ok, "R9 busy held until done", busy_ok, 1);
    check(!busy_o, "R9 busy low with done", busy_o, 0);
    res = pass_o;
    @(negedge clk); #2;
    check(!done_o, "R9 done one cycle", done_o, 0);
    check(pass_o == res, "R10 pass held", pass_o, res);
  endtask

  task automatic t_reset();
    check(!busy_o && !done_o && !pass_o && !rd_req_o && !wr_req_o,
          "R1 reset state", {busy_o, done_o, pass_o, rd_req_o, wr_req_o}, 0);
  endtask

  task automatic t_quick_pass();
    logic r;
    load(8'h00, 8'h00, 8'h00, 8'h00);
    run("R2", r);
    check(r, "R2 pass", r, 1);
    check(rd_cnt == 2 && wr_cnt == 0, "R2 two reads no write", rd_cnt*16 + wr_cnt, 32);
  endtask

  task automatic t_multi_pair();
    logic r;
    load(8'h00, 8'h40, 8'h00, 8'h40);
    script[4] = 8'h40; script[5] = 8'h40;
    run("R3", r);
    check(r, "R3 pass after repeat pairs", r, 1);
    check(rd_cnt == 6 && wr_cnt == 0, "R3 six reads", rd_cnt*16 + wr_cnt, 96);
  endtask

  task automatic t_verify_pass();
    logic r;
    load(8'h00, 8'h60, 8'h20, 8'h20);
    run("R4", r);
    check(r, "R4 pass after verify pair", r, 1);
    check(rd_cnt == 4 && wr_cnt == 0, "R4 four reads no write", rd_cnt*16 + wr_cnt, 64);
  endtask

  task automatic t_verify_fail();
    logic r;
    load(8'h00, 8'h60, 8'h00, 8'h60);
    run("R5", r);
    check(!r, "R5 fail", r, 0);
    check(rd_cnt == 4 && wr_cnt == 1, "R5 four reads one write", rd_cnt*16 + wr_cnt, 65);
    check(wr_seen == 8'hF0, "R5 command value", wr_seen, 8'hF0);
    check(wr_addr_seen == poll_addr_i, "R5 command address", wr_addr_seen, poll_addr_i);
  endtask

  task automatic t_timeout_no_toggle();
    logic r;
    load(8'h20, 8'h20, 8'h20, 8'h20);
    run("R6", r);
    check(r, "R6 timeout ignored when stable", r, 1);
    check(rd_cnt == 2 && wr_cnt == 0, "R6 two reads", rd_cnt*16 + wr_cnt, 32);
  endtask

  task automatic t_budget();
    logic r;
    load(8'h00, 8'h40, 8'h00, 8'h40);
    run("R7", r);
    check(!r, "R7 forced fail", r, 0);
    check(rd_cnt == LIMIT && wr_cnt == 1, "R7 read budget", rd_cnt*16 + wr_cnt, LIMIT*16 + 1);
  endtask

  task automatic t_abandon();
    logic r;
    load(8'h00, 8'h60, 8'h00, 8'h40);
    pulse_start();
    @(negedge clk); @(negedge clk); #1 abandon_i = 1'b1;
    @(negedge clk); #1 abandon_i = 1'b0;
    #1 check(!busy_o, "R8 idle after abandon", busy_o, 0);
    repeat (3) @(negedge clk);
    #2 check(done_cnt == 0 && wr_cnt == 0, "R8 no done no write", done_cnt*16 + wr_cnt, 0);
    load(8'h40, 8'h40, 8'h00, 8'h00);
    run("R8", r);
    check(r && rd_cnt == 2, "R8 resume from first pair", rd_cnt, 2);
  endtask

  task automatic t_start_busy();
    load(8'h00, 8'h40, 8'h00, 8'h40);
    script[4] = 8'h40; script[5] = 8'h40;
    pulse_start();
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
    while (!done_o) @(negedge clk);
    #2 check(pass_o && rd_cnt == 6, "R10 start while busy ignored", rd_cnt, 6);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) script[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_quick_pass();
    t_multi_pair();
    t_verify_pass();
    t_verify_fail();
    t_timeout_no_toggle();
    t_budget();
    t_abandon();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule